// File: doc/BRIEF.md
# Toggle Bit Completion Poller

This block runs on the host side of a parallel NOR-style flash. After software has issued a program or erase command, it pulses `start`. The block then decides whether the embedded operation has finished by issuing status reads to one sector and comparing the toggle bit (bit 6) between two back-to-back reads. While the bit keeps flipping, the block also watches the time-limit flag (bit 5).

When the time-limit flag is seen high while the bit is still flipping, the block makes one more pair of reads. The toggle bit may have stopped just as the flag rose, so this second pair is needed before any verdict. If the bit is still flipping in that second pair, the block issues the reset command write (data `8'hF0`) so that the device goes back to reading array data, and then reports a device failure. A parameterized limit on read pairs guards against a device that keeps toggling without ever raising the flag. The limit gives a separate timeout verdict.

The state machine has these states:
- `ST_IDLE`: waiting for `start`.
- `ST_RD_FIRST` and `ST_RD_SECOND`: the polling pair.
- `ST_CHK_FIRST` and `ST_CHK_SECOND`: the re-check pair after the flag has risen.
- `ST_RST_WR`: the reset command write.
- `ST_FINISH`: the one-cycle `done` pulse.

The transitions are:
- start: IDLE to RD_FIRST.
- first read: RD_FIRST to RD_SECOND.
- stable: RD_SECOND to FINISH.
- flag high: RD_SECOND to CHK_FIRST.
- flag low: RD_SECOND to RD_FIRST.
- poll limit reached: RD_SECOND to FINISH.
- re-check first read: CHK_FIRST to CHK_SECOND.
- stable: CHK_SECOND to FINISH.
- still toggling: CHK_SECOND to RST_WR.
- write acknowledged: RST_WR to FINISH.
- finish: FINISH to IDLE.
- abort: any state to IDLE.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `rd_req`, `wr_req` and `done` are low and `result` is 2'b00.
- R2: An accepted `start` raises `rd_req` in the next cycle. A read completes in each cycle where `rd_req` and `rd_valid` are both high, and reads of one pair follow back to back with `rd_req` held high.
- R3: If bit 6 of `rd_data` is equal in the two reads of a pair, `done` is high in the cycle after the second read completes, with `result` = 2'b01 (pass).
- R4: If bit 6 differs within a pair and bit 5 of the second read is 1, two more reads follow. Equal bit 6 in those two reads gives `done` with `result` = 2'b01.
- R5: If bit 6 still differs in the re-check pair, the block raises `wr_req` with `wr_data` = 8'hF0 and `wr_addr` = the polled sector address, and holds it until `wr_ack`. In the next cycle it gives `done` with `result` = 2'b10 (device failure).
- R6: If bit 6 differs and bit 5 of the second read is 0, a new pair of reads starts in the next cycle.
- R7: After MAX_POLLS consecutive pairs in which bit 6 differs and bit 5 is 0, the block gives `done` with `result` = 2'b11 (timeout) and issues no write.
- R8: `rd_addr` equals the `sector_addr` value captured with the accepted `start`, and it does not change while reads are in progress.
- R9: `abort` forces the block idle in the next cycle, with no `done`. A later `start` begins a fresh read pair with a fresh pair count.
- R10: `start` and changes of `sector_addr` are ignored while a polling sequence is in progress.
- R11: `done` lasts exactly one cycle, and `result` is 2'b00 whenever `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted when idle) |
| abort | input | 1 | Abandon polling, return to idle |
| sector_addr | input | AW | Address of the sector being polled |
| rd_req | output | 1 | Status read request |
| rd_addr | output | AW | Status read address |
| rd_valid | input | 1 | Read data valid, completes a read |
| rd_data | input | 8 | Status byte returned by the flash |
| wr_req | output | 1 | Command write request |
| wr_addr | output | AW | Command write address |
| wr_data | output | 8 | Command write data (reset command) |
| wr_ack | input | 1 | Command write accepted |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Verdict with done: 01 pass, 10 failure, 11 timeout |

## Verification
A wrong state or a stale stored toggle bit shows at the ports within one read, in one of three ways: `rd_req` drops or persists, a stray `wr_req` appears, or the `done` and `result` pair comes out at the wrong cycle or with the wrong code. The bench's reference model tracks the expected request and verdict signals each cycle, so a divergence is reported in the cycle where it first appears rather than at the end of the sequence. A miscounted pair limit shows as a timeout verdict issued one pair early or late.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    localparam int TOGGLE_BIT = 6;
    localparam int LIMIT_BIT  = 5;
    localparam logic [7:0] RESET_CMD = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_SECOND,
        ST_CHK_FIRST,
        ST_CHK_SECOND,
        ST_RST_WR,
        ST_FINISH
    } tpc_state_e;

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_PASS    = 2'b01,
        RES_DEVFAIL = 2'b10,
        RES_TIMEOUT = 2'b11
    } tpc_result_e;
endpackage

// File: rtl/tpc_pair_cmp.sv
module tpc_pair_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tog_in,
    output logic toggled
);
    logic first_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            first_q <= 1'b0;
        else if (load)
            first_q <= tog_in;
    end

    assign toggled = first_q ^ tog_in;
endmodule

// File: rtl/tpc_poll_cnt.sv
module tpc_poll_cnt #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
    import tpc_pkg::*;
#(
    parameter int AW        = 24,
    parameter int MAX_POLLS = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [AW-1:0] sector_addr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [7:0]    rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic          wr_ack,
    output logic          done,
    output logic [1:0]    result
);
    tpc_state_e  state_q, state_d;
    tpc_result_e res_q, res_d;
    logic [AW-1:0] addr_q;

    logic tog_bit, lim_bit, toggled, poll_last;
    logic rd_done, load_first, cnt_clr, cnt_inc, accept;
    logic unused_bits;

    assign tog_bit     = rd_data[TOGGLE_BIT];
    assign lim_bit     = rd_data[LIMIT_BIT];
    assign unused_bits = ^{rd_data[7], rd_data[4:0]};

    assign rd_done = rd_req && rd_valid;
    assign accept  = (state_q == ST_IDLE) && start && !abort;

    assign load_first = rd_done &&
        ((state_q == ST_RD_FIRST) || (state_q == ST_CHK_FIRST));
    assign cnt_clr = accept;
    assign cnt_inc = rd_done && (state_q == ST_RD_SECOND) &&
                     toggled && !lim_bit;

    tpc_pair_cmp u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_first),
        .tog_in  (tog_bit),
        .toggled (toggled)
    );

    tpc_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .last  (poll_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:
                    if (start) state_d = ST_RD_FIRST;
                ST_RD_FIRST:
                    if (rd_valid) state_d = ST_RD_SECOND;
                ST_RD_SECOND:
                    if (rd_valid) begin
                        if (!toggled) begin
                            res_d   = RES_PASS;
                            state_d = ST_FINISH;
                        end else if (lim_bit) begin
                            state_d = ST_CHK_FIRST;
                        end else if (poll_last) begin
                            res_d   = RES_TIMEOUT;
                            state_d = ST_FINISH;
                        end else begin
                            state_d = ST_RD_FIRST;
                        end
                    end
                ST_CHK_FIRST:
                    if (rd_valid) state_d = ST_CHK_SECOND;
                ST_CHK_SECOND:
                    if (rd_valid) begin
                        if (!toggled) begin
                            res_d   = RES_PASS;
                            state_d = ST_FINISH;
                        end else begin
                            state_d = ST_RST_WR;
                        end
                    end
                ST_RST_WR:
                    if (wr_ack) begin
                        res_d   = RES_DEVFAIL;
                        state_d = ST_FINISH;
                    end
                ST_FINISH:
                    state_d = ST_IDLE;
                default:
                    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= RES_NONE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
            if (accept)
                addr_q <= sector_addr;
        end
    end

    // outputs
    always_comb begin
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        done    = 1'b0;
        result  = RES_NONE;
        rd_addr = addr_q;
        wr_addr = addr_q;
        wr_data = RESET_CMD;
        unique case (state_q)
            ST_RD_FIRST, ST_RD_SECOND,
            ST_CHK_FIRST, ST_CHK_SECOND: rd_req = 1'b1;
            ST_RST_WR:                   wr_req = 1'b1;
            ST_FINISH: begin
                done   = 1'b1;
                result = res_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          abort,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          wr_req,
    input logic [7:0]    wr_data,
    input logic          wr_ack,
    input logic          done,
    input logic [1:0]    result
);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> result == 2'b00);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req)) |-> $stable(rd_addr));

    assert_cmd_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_data == 8'hF0);

    assert_one_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    assert_fail_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'b10) |-> $past(wr_req && wr_ack));

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!rd_req && !wr_req && !done));
endmodule

bind toggle_poll_ctrl tpc_checker #(.AW(AW)) u_tpc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (abort),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .wr_req  (wr_req),
    .wr_data (wr_data),
    .wr_ack  (wr_ack),
    .done    (done),
    .result  (result)
);

// File: tb/test_toggle_poll_ctrl.sv
`timescale 1ns/1ps
module test_toggle_poll_ctrl;
    localparam int AW   = 16;
    localparam int MAXP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0;
    logic [AW-1:0] sector_addr = '0;
    logic rd_req, wr_req, done;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] wr_data;
    logic [1:0] result;
    logic rd_valid = 1'b0, wr_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;

    int checks = 0, fails = 0, cycles = 0;

    always #4 clk = ~clk;

    toggle_poll_ctrl #(.AW(AW), .MAX_POLLS(MAXP)) i_toggle_poll_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .sector_addr(sector_addr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .done(done), .result(result));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural flash ----------------
    int  fl_reads = 0, fl_busy = 0, fl_dq5_at = 1000000, fl_gap = 0;
    bit  fl_stuck = 0, fl_tog = 0, wr_seen = 0;
    int  wr_count = 0;

    task automatic fl_cfg(input int busy, input bit stuck, input int dq5_at);
        fl_reads = 0; fl_busy = busy; fl_stuck = stuck; fl_dq5_at = dq5_at;
        fl_tog = 0; fl_gap = 0; wr_count = 0;
    endtask

    always @(negedge clk) begin
        rd_valid <= 1'b0;
        if (rd_req) begin
            if (fl_gap > 0) fl_gap = fl_gap - 1;
            else begin
                rd_valid <= 1'b1;
                rd_data  <= {1'b0, fl_tog, (fl_reads >= fl_dq5_at), 5'h0A};
                if (fl_stuck || fl_reads < fl_busy) fl_tog = ~fl_tog;
                fl_reads = fl_reads + 1;
                fl_gap = (fl_reads % 3 == 0) ? 1 : 0;
            end
        end
        wr_ack <= 1'b0;
        if (wr_req && !wr_seen) begin
            wr_seen = 1;
        end else if (wr_req && wr_seen) begin
            wr_ack <= 1'b1;
            wr_seen = 0;
            wr_count = wr_count + 1;
            chk(wr_data == 8'hF0, "R5 wr_data", wr_data, 8'hF0);
            chk(wr_addr == m_addr, "R5 wr_addr", wr_addr, m_addr);
        end
    end

    // ---------------- reference model ----------------
    // phases: 0 idle, 1/2 poll pair, 3/4 recheck pair, 5 reset write, 7 finish
    int m_ph = 0, m_cnt = 0, m_res = 0;
    bit m_first = 0;
    logic [AW-1:0] m_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_cnt <= 0; m_res <= 0; m_addr <= '0;
        end else if (abort) begin
            m_ph <= 0;
        end else begin
            case (m_ph)
                0: if (start) begin m_ph <= 1; m_cnt <= 0; m_addr <= sector_addr; end
                1, 3: if (rd_valid) begin m_first <= rd_data[6]; m_ph <= m_ph + 1; end
                2: if (rd_valid) begin
                    if (rd_data[6] == m_first) begin m_res <= 1; m_ph <= 7; end
                    else if (rd_data[5]) m_ph <= 3;
                    else if (m_cnt + 1 >= MAXP) begin m_res <= 3; m_ph <= 7; end
                    else begin m_cnt <= m_cnt + 1; m_ph <= 1; end
                end
                4: if (rd_valid) begin
                    if (rd_data[6] == m_first) begin m_res <= 1; m_ph <= 7; end
                    else m_ph <= 5;
                end
                5: if (wr_ack) begin m_res <= 2; m_ph <= 7; end
                default: m_ph <= 0;
            endcase
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(rd_req == (m_ph >= 1 && m_ph <= 4), "R2/R6 rd_req", rd_req, (m_ph >= 1 && m_ph <= 4));
            chk(wr_req == (m_ph == 5), "R5/R7 wr_req", wr_req, (m_ph == 5));
            chk(done == (m_ph == 7), "R11 done", done, (m_ph == 7));
            chk(result == ((m_ph == 7) ? m_res : 0), "R3/R4/R7 result", result, (m_ph == 7) ? m_res : 0);
            if (rd_req) chk(rd_addr == m_addr, "R8 rd_addr", rd_addr, m_addr);
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run(input logic [AW-1:0] a, input int exp_res, input string tag);
        int got;
        got = -1;
        @(negedge clk);
        sector_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_req == 1'b1, "R2 rd_req after start", rd_req, 1);
        for (int i = 0; i < 2000 && got < 0; i++) begin
            @(negedge clk);
            if (done) got = result;
        end
        chk(got == exp_res, tag, got, exp_res);
        @(negedge clk);
        chk(!done && !rd_req, "R11 single done", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_req && !wr_req && !done && result == 0, "R1 in reset", {rd_req, wr_req, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_req && !wr_req && !done && result == 0, "R1 after reset", {rd_req, wr_req, done}, 0);

        fl_cfg(0, 0, 1000000);
        run(16'h1000, 1, "R3 immediate pass");

        fl_cfg(5, 0, 1000000);
        run(16'h2000, 1, "R6 multi-pair pass");

        fl_cfg(4, 0, 3);
        run(16'h3000, 1, "R4 recheck pass");
        chk(wr_count == 0, "R4 no write", wr_count, 0);

        fl_cfg(0, 1, 3);
        run(16'h4000, 2, "R5 device failure");
        chk(wr_count == 1, "R5 one write", wr_count, 1);

        fl_cfg(0, 1, 1000000);
        run(16'h5000, 3, "R7 timeout");
        chk(wr_count == 0, "R7 no write", wr_count, 0);
        chk(fl_reads == 2 * MAXP, "R7 pair count", fl_reads, 2 * MAXP);

        // R10: start and address change ignored while polling
        fl_cfg(0, 1, 1000000);
        @(negedge clk);
        sector_addr = 16'h6000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        sector_addr = 16'h7777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk(rd_addr == 16'h6000, "R10 address kept", rd_addr, 16'h6000);

        // R9: abort then fresh start
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!rd_req && !wr_req && !done, "R9 idle after abort", {rd_req, wr_req, done}, 0);
        repeat (3) @(negedge clk);
        chk(!done, "R9 no done after abort", done, 0);
        fl_cfg(0, 1, 1000000);
        run(16'h8000, 3, "R9 fresh count after restart");
        chk(fl_reads == 2 * MAXP, "R9 full pair budget", fl_reads, 2 * MAXP);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule